// File: doc/BRIEF.md
# Dual-Port Memory with Per-Port Aspect Ratio

This block is a 4096-bit on-chip memory with two independent ports. Each port has its own clock, enable, write enable, address, write data and registered read data. A parameter sets each port's data width to 1, 2, 4, 8 or 16 bits. The address width follows from that choice, so a port always sees the whole 4096-bit array as words of its own width.

The two ports may use different widths over the same storage. A word written through one port can be read through the other, and a fixed rule says which array bits each word covers. Reads are synchronous: data appears on the output only after a rising clock edge. Each port's output register has its own synchronous reset. That reset does not change the stored contents.

Typical uses are width conversion between two clock domains and sharing one buffer between a narrow producer and a wide consumer. Both can run at the same time on separate parts of the array.

Top module: `bram_dual_aspect`

## Requirements
- R1: Total capacity is 4096 bits. A port of width W (1, 2, 4, 8 or 16) has 4096/W words and an address of log2(4096/W) bits. Its top address reaches the last W bits of the array.
- R2: The word at address A of a port of width W covers array bits A·W up to A·W+W−1. Data bit 0 sits at the lowest of those array bits. Example: 4-bit word 4k+j is bits 4j..4j+3 of 16-bit word k.
- R3: A read is synchronous. The read data of the word addressed while the enable is high appears on the output after that rising edge. Changing the address between edges does not change the output.
- R4: With enable and write enable both high at a rising edge, the write data is stored at the addressed word. A later read returns it.
- R5: When a port writes, its output after that edge shows the contents the word held before the write (read-before-write).
- R6: While a port's enable is low, its output holds its value and no write takes place, whatever the write enable, address and data are.
- R7: A port's reset, sampled high at a rising edge, clears that port's output to zero. Reset takes priority over a read. It leaves the array contents unchanged.
- R8: Both ports may read and write on the same edge, provided they touch disjoint bits. Each port's result is then the same as if it had acted alone. Two writes to the same bit on the same edge leave that bit undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous output reset |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | log2(4096/WIDTH_A) | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous output reset |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | log2(4096/WIDTH_B) | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
The bench uses a 4-bit port A against a 16-bit port B.

- **Bit mapping:** narrow nibbles are written and then read back as one wide word, and the reverse. This exposes a swapped nibble order or a wrong offset.
- **Read-before-write:** rewriting a word already holding a known value separates read-before-write from write-first.
- **Address extremes:** the top addresses of both ports must land on the same array bits.
- **Directed cases:**
  - enable low with write enable high, to show no write occurs and the output holds;
  - reset during a read, to show priority and that the array keeps its contents;
  - same-edge writes from both ports to disjoint bits;
  - an address change between edges, to show no asynchronous read path.

// File: rtl/bram_pkg.sv
package bram_pkg;

    // Address width for a port that views TOTAL bits as words of WIDTH bits.
    function automatic int unsigned addr_bits(input int unsigned total, input int unsigned width);
        return $clog2(total / width);
    endfunction

    // True when the width is a power of two no wider than the storage lane.
    function automatic bit width_ok(input int unsigned width, input int unsigned lane);
        return (width != 0) && (width <= lane) && ((width & (width - 1)) == 0);
    endfunction

endpackage

// File: rtl/bram_bank.sv
// One storage bank: written from a single clock, read combinationally by
// its own port and by the peer port.
module bram_bank #(
    parameter int unsigned NWORDS    = 256,
    parameter int unsigned LANE_BITS = 16,
    localparam int unsigned IW       = $clog2(NWORDS)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [IW-1:0]        idx,
    input  logic [LANE_BITS-1:0] wdata,
    output logic [LANE_BITS-1:0] rdata,
    input  logic [IW-1:0]        peer_idx,
    output logic [LANE_BITS-1:0] peer_rdata
);

    logic [LANE_BITS-1:0] mem_q [NWORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata      = mem_q[idx];
    assign peer_rdata = mem_q[peer_idx];

endmodule

// File: rtl/bram_port.sv
// Port logic: maps a WIDTH-bit word onto a lane of the shared array.
// Stored value of a bit = own bank bit XOR peer bank bit.
module bram_port #(
    parameter int unsigned TOTAL_BITS = 4096,
    parameter int unsigned LANE_BITS  = 16,
    parameter int unsigned WIDTH      = 16,
    localparam int unsigned AW  = bram_pkg::addr_bits(TOTAL_BITS, WIDTH),
    localparam int unsigned BPW = $clog2(TOTAL_BITS),
    localparam int unsigned OW  = $clog2(LANE_BITS),
    localparam int unsigned IW  = BPW - OW,
    localparam int unsigned WSH = $clog2(WIDTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [WIDTH-1:0]     din,
    output logic [WIDTH-1:0]     dout,
    output logic [IW-1:0]        word_idx,
    input  logic [LANE_BITS-1:0] own_word,
    input  logic [LANE_BITS-1:0] peer_word,
    output logic                 bank_we,
    output logic [LANE_BITS-1:0] bank_wdata
);

    typedef struct packed {
        logic [WIDTH-1:0] dout;
    } port_state_t;

    port_state_t state_d, state_q;

    logic [BPW-1:0]       bit_pos;
    logic [OW-1:0]        offset;
    logic [LANE_BITS-1:0] cur_word;
    logic [LANE_BITS-1:0] lane_mask;
    logic [LANE_BITS-1:0] placed;
    logic [LANE_BITS-1:0] shifted;

    always_comb begin
        bit_pos    = BPW'(addr) << WSH;
        word_idx   = bit_pos[BPW-1:OW];
        offset     = bit_pos[OW-1:0];
        cur_word   = own_word ^ peer_word;
        lane_mask  = LANE_BITS'({WIDTH{1'b1}}) << offset;
        placed     = LANE_BITS'(din) << offset;
        shifted    = cur_word >> offset;

        bank_we    = en && we;
        bank_wdata = (own_word & ~lane_mask) | ((placed ^ peer_word) & lane_mask);

        state_d = state_q;
        if (rst) begin
            state_d.dout = '0;
        end else if (en) begin
            state_d.dout = shifted[WIDTH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign dout = state_q.dout;

endmodule

// File: rtl/bram_dual_aspect.sv
module bram_dual_aspect #(
    parameter int unsigned TOTAL_BITS = 4096,
    parameter int unsigned LANE_BITS  = 16,
    parameter int unsigned WIDTH_A    = 16,
    parameter int unsigned WIDTH_B    = 16,
    localparam int unsigned AW_A   = bram_pkg::addr_bits(TOTAL_BITS, WIDTH_A),
    localparam int unsigned AW_B   = bram_pkg::addr_bits(TOTAL_BITS, WIDTH_B),
    localparam int unsigned NWORDS = TOTAL_BITS / LANE_BITS,
    localparam int unsigned IW     = $clog2(NWORDS)
) (
    input  logic               clk_a,
    input  logic               rst_a,
    input  logic               en_a,
    input  logic               we_a,
    input  logic [AW_A-1:0]    addr_a,
    input  logic [WIDTH_A-1:0] din_a,
    output logic [WIDTH_A-1:0] dout_a,
    input  logic               clk_b,
    input  logic               rst_b,
    input  logic               en_b,
    input  logic               we_b,
    input  logic [AW_B-1:0]    addr_b,
    input  logic [WIDTH_B-1:0] din_b,
    output logic [WIDTH_B-1:0] dout_b
);

    logic [IW-1:0]        idx_a, idx_b;
    logic [LANE_BITS-1:0] own_a, own_b, peer_a, peer_b;
    logic                 bwe_a, bwe_b;
    logic [LANE_BITS-1:0] bwd_a, bwd_b;

    bram_port #(
        .TOTAL_BITS(TOTAL_BITS), .LANE_BITS(LANE_BITS), .WIDTH(WIDTH_A)
    ) u_port_a (
        .clk(clk_a), .rst(rst_a), .en(en_a), .we(we_a),
        .addr(addr_a), .din(din_a), .dout(dout_a),
        .word_idx(idx_a), .own_word(own_a), .peer_word(peer_a),
        .bank_we(bwe_a), .bank_wdata(bwd_a)
    );

    bram_port #(
        .TOTAL_BITS(TOTAL_BITS), .LANE_BITS(LANE_BITS), .WIDTH(WIDTH_B)
    ) u_port_b (
        .clk(clk_b), .rst(rst_b), .en(en_b), .we(we_b),
        .addr(addr_b), .din(din_b), .dout(dout_b),
        .word_idx(idx_b), .own_word(own_b), .peer_word(peer_b),
        .bank_we(bwe_b), .bank_wdata(bwd_b)
    );

    bram_bank #(.NWORDS(NWORDS), .LANE_BITS(LANE_BITS)) u_bank_a (
        .clk(clk_a), .we(bwe_a), .idx(idx_a), .wdata(bwd_a), .rdata(own_a),
        .peer_idx(idx_b), .peer_rdata(peer_b)
    );

    bram_bank #(.NWORDS(NWORDS), .LANE_BITS(LANE_BITS)) u_bank_b (
        .clk(clk_b), .we(bwe_b), .idx(idx_b), .wdata(bwd_b), .rdata(own_b),
        .peer_idx(idx_a), .peer_rdata(peer_a)
    );

endmodule

// File: rtl/bram_dual_aspect_chk.sv
// Property checker. The cross-port guards sample the other port on this
// port's clock, so the write-then-read properties assume a shared clock.
module bram_dual_aspect_chk #(
    parameter int unsigned WIDTH_A = 16,
    parameter int unsigned WIDTH_B = 16,
    parameter int unsigned AW_A    = 8,
    parameter int unsigned AW_B    = 8
) (
    input logic               clk_a,
    input logic               rst_a,
    input logic               en_a,
    input logic               we_a,
    input logic [AW_A-1:0]    addr_a,
    input logic [WIDTH_A-1:0] din_a,
    input logic [WIDTH_A-1:0] dout_a,
    input logic               clk_b,
    input logic               rst_b,
    input logic               en_b,
    input logic               we_b,
    input logic [AW_B-1:0]    addr_b,
    input logic [WIDTH_B-1:0] din_b,
    input logic [WIDTH_B-1:0] dout_b
);

    // R6: idle port holds its output
    p_hold_a_r6: assert property (@(posedge clk_a) disable iff (rst_a)
        (!en_a && !rst_a) |=> $stable(dout_a));
    p_hold_b_r6: assert property (@(posedge clk_b) disable iff (rst_b)
        (!en_b && !rst_b) |=> $stable(dout_b));

    // R7: reset clears the output register on the next edge
    p_rst_a_r7: assert property (@(posedge clk_a)
        rst_a |=> (dout_a == '0));
    p_rst_b_r7: assert property (@(posedge clk_b)
        rst_b |=> (dout_b == '0));

    // R4/R5: a write followed by an access to the same word returns that data
    // (second access may itself be a write: read-before-write shows the first)
    p_wr_rd_a_r5: assert property (@(posedge clk_a) disable iff (rst_a)
        (en_a && we_a && !(en_b && we_b)) ##1
        (en_a && !(en_b && we_b) && addr_a == $past(addr_a))
        |=> (dout_a == $past(din_a, 2)));
    p_wr_rd_b_r5: assert property (@(posedge clk_b) disable iff (rst_b)
        (en_b && we_b && !(en_a && we_a)) ##1
        (en_b && !(en_a && we_a) && addr_b == $past(addr_b))
        |=> (dout_b == $past(din_b, 2)));

endmodule

bind bram_dual_aspect bram_dual_aspect_chk #(
    .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .AW_A(AW_A), .AW_B(AW_B)
) u_chk (
    .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .we_a(we_a),
    .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .we_b(we_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
);

// File: tb/bram_dual_aspect_bench.sv
`timescale 1ns/1ps
module bram_dual_aspect_bench;

    localparam int unsigned WA  = 4;
    localparam int unsigned WB  = 16;
    localparam int unsigned AWA = 10;
    localparam int unsigned AWB = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_a, en_a, we_a, rst_b, en_b, we_b;
    logic [AWA-1:0] addr_a;
    logic [AWB-1:0] addr_b;
    logic [WA-1:0]  din_a, dout_a;
    logic [WB-1:0]  din_b, dout_b;

    int checks = 0;
    int errors = 0;

    bram_dual_aspect #(.WIDTH_A(WA), .WIDTH_B(WB)) u_bram_dual_aspect (
        .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .we_a(we_a),
        .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
        .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .we_b(we_b),
        .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
    );

    typedef struct packed {
        logic        sel;   // 0: port A (4-bit), 1: port B (16-bit)
        logic        we;
        logic        chk;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [15:0] din;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 4'd4, 12'd0,    16'h0001, 16'h0000}, // R4 fill nibbles
        '{1'b0, 1'b1, 1'b0, 4'd4, 12'd1,    16'h0002, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 4'd4, 12'd2,    16'h0003, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 4'd4, 12'd3,    16'h0004, 16'h0000},
        '{1'b1, 1'b0, 1'b1, 4'd2, 12'd0,    16'h0000, 16'h4321}, // R2 narrow->wide
        '{1'b1, 1'b1, 1'b0, 4'd4, 12'd1,    16'hBEEF, 16'h0000},
        '{1'b0, 1'b0, 1'b1, 4'd2, 12'd4,    16'h0000, 16'h000F}, // R2 wide->narrow
        '{1'b0, 1'b0, 1'b1, 4'd2, 12'd7,    16'h0000, 16'h000B},
        '{1'b0, 1'b0, 1'b1, 4'd2, 12'd5,    16'h0000, 16'h000E},
        '{1'b0, 1'b1, 1'b1, 4'd5, 12'd0,    16'h000A, 16'h0001}, // R5 old data
        '{1'b0, 1'b0, 1'b1, 4'd4, 12'd0,    16'h0000, 16'h000A},
        '{1'b1, 1'b0, 1'b1, 4'd2, 12'd0,    16'h0000, 16'h432A},
        '{1'b1, 1'b1, 1'b1, 4'd5, 12'd0,    16'h5555, 16'h432A}, // R5 on wide port
        '{1'b0, 1'b0, 1'b1, 4'd2, 12'd3,    16'h0000, 16'h0005},
        '{1'b1, 1'b1, 1'b0, 4'd1, 12'd255,  16'h8001, 16'h0000}, // R1 top word
        '{1'b0, 1'b0, 1'b1, 4'd1, 12'd1023, 16'h0000, 16'h0008},
        '{1'b0, 1'b0, 1'b1, 4'd1, 12'd1020, 16'h0000, 16'h0001},
        '{1'b1, 1'b0, 1'b1, 4'd3, 12'd1,    16'h0000, 16'hBEEF}  // R3
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        en_a = 1'b0; we_a = 1'b0; addr_a = '0; din_a = '0;
        en_b = 1'b0; we_b = 1'b0; addr_b = '0; din_b = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_a = 1'b1; rst_b = 1'b1;
        repeat (2) @(negedge clk);
        // R7: reset state
        check("R7 reset dout_a", 16'(dout_a), 16'h0);
        check("R7 reset dout_b", dout_b, 16'h0);
        rst_a = 1'b0; rst_b = 1'b0;

        for (int i = 0; i < NV; i++) begin
            idle();
            if (VEC[i].sel == 1'b0) begin
                en_a = 1'b1; we_a = VEC[i].we;
                addr_a = VEC[i].addr[AWA-1:0]; din_a = VEC[i].din[WA-1:0];
            end else begin
                en_b = 1'b1; we_b = VEC[i].we;
                addr_b = VEC[i].addr[AWB-1:0]; din_b = VEC[i].din;
            end
            @(negedge clk);
            if (VEC[i].chk) begin
                if (VEC[i].sel == 1'b0)
                    check($sformatf("R%0d vec %0d port A", VEC[i].req, i), 16'(dout_a), VEC[i].exp);
                else
                    check($sformatf("R%0d vec %0d port B", VEC[i].req, i), dout_b, VEC[i].exp);
            end
        end

        // Array now: A words 0..3 = 5, A words 4..7 = F,E,E,B (0xBEEF)
        // R6: enable low with write enable high neither writes nor moves dout
        idle(); en_a = 1'b1; addr_a = 10'd4;
        @(negedge clk);
        check("R6 setup read", 16'(dout_a), 16'h000F);
        idle(); we_a = 1'b1; addr_a = 10'd4; din_a = 4'h3;
        @(negedge clk);
        check("R6 hold cycle 1", 16'(dout_a), 16'h000F);
        addr_a = 10'd5;
        @(negedge clk);
        check("R6 hold cycle 2", 16'(dout_a), 16'h000F);
        idle(); en_b = 1'b1; addr_b = 8'd1;
        @(negedge clk);
        check("R6 no write seen on B", dout_b, 16'hBEEF);

        // R7: reset beats a read; array keeps its data; B unaffected (R8)
        idle(); rst_a = 1'b1; en_a = 1'b1; addr_a = 10'd5; en_b = 1'b1; addr_b = 8'd0;
        @(negedge clk);
        check("R7 reset over read", 16'(dout_a), 16'h0);
        check("R8 B during A reset", dout_b, 16'h5555);
        rst_a = 1'b0;
        @(negedge clk);
        check("R7 array kept after reset", 16'(dout_a), 16'h000E);

        // R8: same-edge writes to disjoint bits
        idle();
        en_a = 1'b1; we_a = 1'b1; addr_a = 10'd8; din_a = 4'h7;
        en_b = 1'b1; we_b = 1'b1; addr_b = 8'd3; din_b = 16'h1234;
        @(negedge clk);
        idle(); en_a = 1'b1; addr_a = 10'd8; en_b = 1'b1; addr_b = 8'd3;
        @(negedge clk);
        check("R8 A word after dual write", 16'(dout_a), 16'h0007);
        check("R8 B word after dual write", dout_b, 16'h1234);
        idle(); en_a = 1'b1; addr_a = 10'd12; en_b = 1'b1; addr_b = 8'd2;
        // R3: address change between edges leaves the output alone
        #1;
        check("R3 no async read", 16'(dout_a), 16'h0007);
        @(negedge clk);
        check("R2 low nibble of B word 3", 16'(dout_a), 16'h0004);
        check("R2 B word 2 low nibble", dout_b & 16'h000F, 16'h0007);

        idle();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule